// File: doc/BRIEF.md
# Flow-Through Burst Synchronous SRAM

This block is a single-clock synchronous static RAM. It accepts a new command on every active clock cycle, so reads and writes can alternate with no idle cycle between them. Every command and address is registered on the rising edge. Read data flows straight from the array to the output in the cycle after the read address is registered. Write data for a command is taken one active cycle after its address. A later read of the same location therefore always returns the freshly written word.

Each access selects a group of four words. A 2-bit burst counter, seeded from the two lowest address bits, steps through that group. An advance control either loads a new address and command or steps the counter and repeats the previous command. An order input picks either a linear or an interleaved stepping order. A low-active clock enable freezes all state. Three chip-enable inputs must all agree before any access takes place.

Top module: `fbsram_top`

## Requirements
- R1: While rst_ni is low, and in the first cycle after reset, rvalid_o is 0 and rdata_o is 0.
- R2: When cke_n_i is 1 at a rising edge, every other synchronous input is ignored. No state or memory changes, and rdata_o and rvalid_o keep their values.
- R3: A load cycle (cke_n_i=0, adv_i=0) is a deselect unless ce1_n_i=0, ce2_i=1 and ce3_n_i=0. After a deselect, rvalid_o=0 and rdata_o=0.
- R4: A selected load with we_n_i=1 is a read. In the next cycle rvalid_o=1 and rdata_o holds the addressed word. Whenever rvalid_o=0, rdata_o=0.
- R5: A selected load with we_n_i=0 is a write. rvalid_o is 0 in the following cycle. The data on wdata_i at the next active edge is stored at the address.
- R6: bw_n_i is sampled with each command. Bit 0 low enables lane wdata[8:0] and bit 1 low enables lane wdata[17:9]. Lanes whose bit is high keep their old contents.
- R7: A write with bw_n_i=2'b11 is an abort and changes no memory.
- R8: With order_i=0 captured at load, the burst addresses are seed, seed+1, seed+2, seed+3 modulo 4. The first beat always uses the seed.
- R9: With order_i=1 captured at load, the burst addresses are seed XOR 0, 1, 2, 3.
- R10: addr_i[7:2] captured at load stays fixed for the whole burst. The low two bits wrap within the group of four.
- R11: A read issued in the cycle right after a write, with no wait cycle, returns the data of that write. A write right after a read needs no wait cycle either.
- R12: An active cycle with adv_i=1 steps the counter and repeats the previous command type: read, write or deselect. we_n_i, the chip enables, order_i and addr_i are ignored on such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_n_i | input | 1 | Clock enable, active low; high freezes the block |
| ce1_n_i | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_n_i | input | 1 | Chip enable, active low |
| adv_i | input | 1 | 1 = step burst, 0 = load new address and command |
| we_n_i | input | 1 | 0 = write, 1 = read (on load) |
| bw_n_i | input | 2 | Per-lane write enables, active low |
| order_i | input | 1 | 1 = interleaved, 0 = linear burst order |
| addr_i | input | 8 | Word address |
| wdata_i | input | 18 | Write data, one active cycle after its address |
| rdata_o | output | 18 | Flow-through read data |
| rvalid_o | output | 1 | Read data valid |

## Verification
The bench sends back-to-back single writes and reads to tell data placement apart from command timing. It runs linear and interleaved bursts from several seeds; these separate the two orders and reveal any carry into the upper address bits. Alternating write and read cycles on one address show whether write data lands a cycle late without a wait state. Partial-lane writes, aborts, bad chip-enable combinations and clock-enable holds inserted mid-burst and mid-write each show whether the ignored inputs leak into memory or into the outputs.

// File: rtl/fbsram_pkg.sv
package fbsram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/fbsram_burst.sv
module fbsram_burst #(
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [CW-1:0] seed_i,
  input  logic          order_i,
  output logic [CW-1:0] offset_o
);
  logic [CW-1:0] seed_q, cnt_q;
  logic          ilv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_q <= '0;
      cnt_q  <= '0;
      ilv_q  <= 1'b0;
    end else if (load_i) begin
      seed_q <= seed_i;
      cnt_q  <= '0;
      ilv_q  <= order_i;
    end else if (step_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign offset_o = ilv_q ? (seed_q ^ cnt_q) : (seed_q + cnt_q);

  assert_first_beat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> offset_o == $past(seed_i));
  assert_step_moves_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> offset_o != $past(offset_o));
endmodule

// File: rtl/fbsram_ctrl.sv
module fbsram_ctrl
  import fbsram_pkg::*;
#(
  parameter int HW = 6,
  parameter int NB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          adv_i,
  input  logic          sel_i,
  input  logic          we_n_i,
  input  logic [NB-1:0] bw_n_i,
  input  logic [HW-1:0] hi_i,
  output op_e           op_o,
  output logic [HW-1:0] hi_o,
  output logic [NB-1:0] bw_n_o
);
  op_e op_q;
  logic [HW-1:0] hi_q;
  logic [NB-1:0] bw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= OP_NONE;
      hi_q <= '0;
      bw_q <= '1;
    end else if (active_i) begin
      bw_q <= bw_n_i;
      if (!adv_i) begin
        hi_q <= hi_i;
        if (!sel_i)       op_q <= OP_NONE;
        else if (we_n_i)  op_q <= OP_READ;
        else              op_q <= OP_WRITE;
      end
    end
  end

  assign op_o   = op_q;
  assign hi_o   = hi_q;
  assign bw_n_o = bw_q;

  assert_deselect_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !adv_i && !sel_i) |=> op_o == OP_NONE);
  assert_keep_op_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && adv_i) |=> (op_o == $past(op_o)) && $stable(hi_o));
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> $stable(op_o) && $stable(hi_o) && $stable(bw_n_o));
endmodule

// File: rtl/fbsram_array.sv
module fbsram_array #(
  parameter int DW     = 18,
  parameter int BYTE_W = 9,
  parameter int AW     = 8,
  localparam int NB    = DW / BYTE_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [NB-1:0] lane_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && lane_en_i[g]) mem[addr_i] <= wdata_i[g*BYTE_W +: BYTE_W];
    end

    assign rdata_o[g*BYTE_W +: BYTE_W] = mem[addr_i];
  end
endmodule

// File: rtl/fbsram_top.sv
module fbsram_top
  import fbsram_pkg::*;
#(
  parameter int DW     = 18,
  parameter int BYTE_W = 9,
  parameter int AW     = 8,
  localparam int NB    = DW / BYTE_W,
  localparam int CW    = 2,
  localparam int HW    = AW - CW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cke_n_i,
  input  logic          ce1_n_i,
  input  logic          ce2_i,
  input  logic          ce3_n_i,
  input  logic          adv_i,
  input  logic          we_n_i,
  input  logic [NB-1:0] bw_n_i,
  input  logic          order_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  logic          active, sel, load, step;
  op_e           op;
  logic [HW-1:0] hi;
  logic [NB-1:0] bw_n;
  logic [CW-1:0] offset;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] arr_rdata;

  assign active = !cke_n_i;
  assign sel    = !ce1_n_i && ce2_i && !ce3_n_i;
  assign load   = active && !adv_i;
  assign step   = active && adv_i;

  fbsram_ctrl #(.HW(HW), .NB(NB)) u_ctrl (
    .clk_i, .rst_ni,
    .active_i (active),
    .adv_i,
    .sel_i    (sel),
    .we_n_i,
    .bw_n_i,
    .hi_i     (addr_i[AW-1:CW]),
    .op_o     (op),
    .hi_o     (hi),
    .bw_n_o   (bw_n)
  );

  fbsram_burst #(.CW(CW)) u_burst (
    .clk_i, .rst_ni,
    .load_i   (load),
    .step_i   (step),
    .seed_i   (addr_i[CW-1:0]),
    .order_i,
    .offset_o (offset)
  );

  assign cur_addr = {hi, offset};

  // write completes at the active edge after its address was registered
  fbsram_array #(.DW(DW), .BYTE_W(BYTE_W), .AW(AW)) u_array (
    .clk_i,
    .we_i      (active && op == OP_WRITE),
    .lane_en_i (~bw_n),
    .addr_i    (cur_addr),
    .wdata_i,
    .rdata_o   (arr_rdata)
  );

  assign rvalid_o = (op == OP_READ);
  assign rdata_o  = rvalid_o ? arr_rdata : '0;

  assert_read_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && sel && we_n_i) |=> rvalid_o);
  assert_write_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && sel && !we_n_i) |=> !rvalid_o);
  assert_freeze_out_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_n_i |=> $stable(rvalid_o) && $stable(rdata_o));
  assert_idle_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> rdata_o == '0);
endmodule

// File: tb/fbsram_top_bench.sv
module fbsram_top_bench;
  localparam logic [2:0] SEL = 3'b010; // {ce1_n, ce2, ce3_n}

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cke_n_i = 1'b0, ce1_n_i = 1'b1, ce2_i = 1'b0, ce3_n_i = 1'b1;
  logic        adv_i = 1'b0, we_n_i = 1'b1, order_i = 1'b0;
  logic [1:0]  bw_n_i = 2'b11;
  logic [7:0]  addr_i = '0;
  logic [17:0] wdata_i = '0;
  logic [17:0] rdata_o;
  logic        rvalid_o;

  always #5 clk = ~clk;

  fbsram_top u_fbsram_top (
    .clk_i(clk), .rst_ni, .cke_n_i, .ce1_n_i, .ce2_i, .ce3_n_i, .adv_i,
    .we_n_i, .bw_n_i, .order_i, .addr_i, .wdata_i, .rdata_o, .rvalid_o
  );

  typedef struct {
    int          due;
    logic        v;
    logic [17:0] d;
    string       tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0, cyc_cnt = 0;
  bit done = 0;

  // reference state
  logic [17:0] ref_mem [256];
  int   m_op = 0; // 0 none, 1 read, 2 write
  logic [5:0] m_hi = '0;
  logic [1:0] m_seed = '0, m_k = '0, m_bw = 2'b11;
  logic m_ord = 1'b0;
  logic [17:0] pend_wd = '0;

  function automatic logic [7:0] m_addr();
    return {m_hi, m_ord ? (m_seed ^ m_k) : (m_seed + m_k)};
  endfunction

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc_cnt) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (rvalid_o !== e.v || rdata_o !== e.d) begin
        errors++;
        $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                 e.tag, rvalid_o, rdata_o, e.v, e.d);
      end
    end
  end

  task automatic cyc(input logic ckn, input logic [2:0] ce, input logic adv,
                     input logic wen, input logic [1:0] bwn, input logic ordr,
                     input logic [7:0] a, input logic [17:0] d_next, input string tag);
    exp_t e;
    @(posedge clk); #2;
    cke_n_i = ckn; {ce1_n_i, ce2_i, ce3_n_i} = ce; adv_i = adv; we_n_i = wen;
    bw_n_i = bwn; order_i = ordr; addr_i = a; wdata_i = pend_wd;
    if (!ckn) begin
      if (m_op == 2) begin
        if (!m_bw[0]) ref_mem[m_addr()][8:0]  = pend_wd[8:0];
        if (!m_bw[1]) ref_mem[m_addr()][17:9] = pend_wd[17:9];
      end
      if (!adv) begin
        m_op = (ce != SEL) ? 0 : (wen ? 1 : 2);
        m_hi = a[7:2]; m_seed = a[1:0]; m_k = '0; m_ord = ordr;
      end else m_k = m_k + 1'b1;
      m_bw = bwn;
    end
    e.due = cyc_cnt + 1;
    e.v   = (m_op == 1);
    e.d   = e.v ? ref_mem[m_addr()] : '0;
    e.tag = tag;
    q.push_back(e);
    pend_wd = d_next;
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] bwn, input logic [17:0] d, input string tag);
    cyc(1'b0, SEL, 1'b0, 1'b0, bwn, 1'b0, a, d, tag);
  endtask
  task automatic rd(input logic [7:0] a, input logic ordr, input string tag);
    cyc(1'b0, SEL, 1'b0, 1'b1, 2'b11, ordr, a, 18'h0, tag);
  endtask
  task automatic step(input logic [1:0] bwn, input logic [17:0] d, input string tag);
    // junk on ignored inputs (R12)
    cyc(1'b0, 3'b111, 1'b1, ~we_n_i, bwn, ~order_i, 8'hFF, d, tag);
  endtask
  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (rvalid_o !== 1'b0 || rdata_o !== '0) begin
      errors++;
      $display("FAIL R1: rvalid=%0b rdata=%h expected 0 0", rvalid_o, rdata_o);
    end
    rst_ni = 1'b1;
    @(negedge clk);
    checks++;
    if (rvalid_o !== 1'b0 || rdata_o !== '0) begin
      errors++;
      $display("FAIL R1: rvalid=%0b rdata=%h expected 0 0 after reset", rvalid_o, rdata_o);
    end

    // R5: back-to-back single writes
    for (int i = 0; i < 24; i++) wr(8'(i), 2'b00, 18'h2A000 ^ 18'(i * 37), "R5");
    // R4 / R11: reads directly after writes
    for (int i = 0; i < 24; i++) rd(8'(i), 1'b0, "R4");

    // R8 / R10: linear write burst seeded at 2 in group 4 (0x12,0x13,0x10,0x11)
    wr(8'h12, 2'b00, 18'h11111, "R8");
    step(2'b00, 18'h22222, "R8");
    step(2'b00, 18'h33333, "R8");
    step(2'b00, 18'h04444, "R10");
    rd(8'h17, 1'b0, "R10"); // next group untouched
    for (int i = 16; i < 20; i++) rd(8'(i), 1'b0, "R10");
    // linear read burst from seed 3
    rd(8'h13, 1'b0, "R8");
    for (int i = 0; i < 3; i++) step(2'b11, 18'h0, "R8");
    // R9: interleaved read from seed 1, interleaved write from seed 3
    rd(8'h11, 1'b1, "R9");
    for (int i = 0; i < 3; i++) step(2'b11, 18'h0, "R9");
    cyc(1'b0, SEL, 1'b0, 1'b0, 2'b00, 1'b1, 8'h17, 18'h0A0A0, "R9");
    step(2'b00, 18'h0B0B0, "R9");
    step(2'b00, 18'h0C0C0, "R9");
    step(2'b00, 18'h0D0D0, "R9");
    rd(8'h14, 1'b0, "R9");
    for (int i = 0; i < 3; i++) step(2'b11, 18'h0, "R9");

    // R6: single-lane writes
    wr(8'h03, 2'b10, 18'h3FFFF, "R6");
    wr(8'h04, 2'b01, 18'h3FFFF, "R6");
    rd(8'h03, 1'b0, "R6");
    rd(8'h04, 1'b0, "R6");
    // R7: abort, also inside a burst
    wr(8'h05, 2'b11, 18'h15555, "R7");
    rd(8'h05, 1'b0, "R7");
    wr(8'h08, 2'b00, 18'h01234, "R7");
    step(2'b11, 18'h3FFFF, "R7");
    rd(8'h09, 1'b0, "R7");
    rd(8'h08, 1'b0, "R7");

    // R3: each bad chip-enable combination deselects
    cyc(1'b0, 3'b110, 1'b0, 1'b1, 2'b11, 1'b0, 8'h02, 18'h0, "R3");
    cyc(1'b0, 3'b000, 1'b0, 1'b1, 2'b11, 1'b0, 8'h02, 18'h0, "R3");
    cyc(1'b0, 3'b011, 1'b0, 1'b0, 2'b00, 1'b0, 8'h02, 18'h3FFFF, "R3");
    cyc(1'b0, 3'b111, 1'b0, 1'b0, 2'b00, 1'b0, 8'h02, 18'h3FFFF, "R3");
    step(2'b00, 18'h3FFFF, "R12"); // deselect continues
    rd(8'h02, 1'b0, "R3");

    // R2: clock enable holds a read, then holds a write in flight
    rd(8'h06, 1'b0, "R2");
    cyc(1'b1, SEL, 1'b0, 1'b0, 2'b00, 1'b0, 8'h07, 18'h3FFFF, "R2");
    cyc(1'b1, SEL, 1'b1, 1'b0, 2'b00, 1'b1, 8'h00, 18'h3FFFF, "R2");
    step(2'b11, 18'h0, "R12");
    wr(8'h0A, 2'b00, 18'h2BEEF, "R2");
    cyc(1'b1, SEL, 1'b0, 1'b1, 2'b11, 1'b0, 8'h0B, 18'h2BEEF, "R2");
    cyc(1'b1, SEL, 1'b0, 1'b1, 2'b11, 1'b0, 8'h0B, 18'h2BEEF, "R2");
    rd(8'h0A, 1'b0, "R2");
    rd(8'h0B, 1'b0, "R2");

    // R11: alternating write/read on one address
    wr(8'h20, 2'b00, 18'h1AAAA, "R11");
    rd(8'h20, 1'b0, "R11");
    wr(8'h20, 2'b00, 18'h05555, "R11");
    rd(8'h20, 1'b0, "R11");
    wr(8'h21, 2'b00, 18'h0F0F0, "R11");
    rd(8'h20, 1'b0, "R11");
    rd(8'h21, 1'b0, "R11");
    cyc(1'b0, 3'b110, 1'b0, 1'b1, 2'b11, 1'b0, 8'h00, 18'h0, "R3");
    cyc(1'b0, 3'b110, 1'b0, 1'b1, 2'b11, 1'b0, 8'h00, 18'h0, "R3");

    repeat (3) @(posedge clk);
    #3;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R4: %0d pending expectations, expected 0", q.size());
    end
    finish_run();
  end
endmodule